// File: doc/BRIEF.md
# Host Controller Interrupt Gating Unit

This block merges four status flags from a host controller core with four software enable bits into a single level-sensitive interrupt line. Two sources, frame-list rollover and port change, raise the line as soon as their status and enable bits are both set. The other two, transaction completion and transaction error, wait for the next interrupt-threshold tick before they take effect.

Software reaches the block through a simple register port. A write strobe carries a one-bit register select and a 32-bit data word, and read data is returned combinationally for the selected register. Software acknowledges a source by writing a 1 to its status bit. The controller core sets status bits with one-cycle pulses on `sts_set`. The threshold tick arrives from an interval generator outside this block.

No data streams through the block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or a single-cycle strobe, and it is sampled on each rising clock edge.

Top module: `irq_gate_top`

## Requirements
- R1: After reset, the enable register reads 0, the status register reads 0, and `irq` is low.
- R2: A write with `reg_sel`=0 loads `reg_wdata[3:0]` into the enable register. Bit 3 is frame-list rollover, bit 2 is port change, bit 1 is transaction error and bit 0 is transaction completion. Bits 31:4 are ignored on write and read back as 0, and this also holds for the status register (`reg_sel`=1).
- R3: A 1 on `sts_set[i]` sets status bit i at the next clock edge, whatever the enable bit holds.
- R4: A write with `reg_sel`=1 clears each status bit whose `reg_wdata` bit is 1. Status bits whose data bit is 0 keep their value.
- R5: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R6: Bits 3 and 2 drive `irq` high in the cycle after enable and status both become 1, without waiting for a tick.
- R7: Bits 1 and 0 leave `irq` low until a `thresh_tick` is sampled while that bit's enable and status are both 1. `irq` then rises in the cycle after the tick.
- R8: A tick that arrives in the same cycle as the `sts_set` pulse does not qualify the source, because the status bit is not yet set. The source waits for a later tick.
- R9: Clearing a source's status or enable bit removes its contribution to `irq` in the cycle after the write. If a deferred source is set again after this, it needs a new tick.
- R10: `irq` is a level. It stays high for as long as any qualified source remains set, across further ticks and across clearing of other sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = enable, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sts_set | input | 4 | Status set pulses from the controller core |
| thresh_tick | input | 1 | Interrupt-threshold boundary pulse |
| irq | output | 1 | Level interrupt to the host |

## Verification
A stuck or lost status bit shows up on `reg_rdata` when the status register is read right after the set or clear edge, and on `irq` in that same cycle if the source is enabled. A wrong deferral flag shows up in one of two ways. If the flag is held high, `irq` rises on an enabled transaction source with no tick. If the flag is left set after an acknowledge, `irq` rises immediately when the source is set again. The bench looks for both of these in the cycle after the set pulse, before any tick is issued. Priority errors between set and clear appear at the very next status read.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned DATA_W = 32;
  // Register select codes
  localparam logic SEL_ENABLE = 1'b0;
  localparam logic SEL_STATUS = 1'b1;
  // Sources that fire without waiting for a threshold tick
  localparam logic [NSRC-1:0] IMMEDIATE_MASK = 4'b1100;
endpackage

// File: rtl/irq_gate_enable.sv
module irq_gate_enable #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_q <= '0;
    else if (load) en_q <= load_val;
  end
endmodule

// File: rtl/irq_gate_status.sv
module irq_gate_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] sts_q
);
  logic [N-1:0] sts_d;

  // Set has priority over a clear in the same cycle
  always_comb sts_d = (sts_q & ~sw_clr) | hw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end
endmodule

// File: rtl/irq_gate_defer.sv
module irq_gate_defer #(
  parameter int unsigned     N        = 4,
  parameter logic [N-1:0]    IMM_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_q,
  input  logic [N-1:0] sts_q,
  input  logic         tick,
  output logic         irq
);
  logic [N-1:0] hit;
  logic [N-1:0] qual;

  always_comb hit = en_q & sts_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    if (IMM_MASK[i]) begin : g_now
      always_comb qual[i] = hit[i];
    end else begin : g_wait
      logic armed_q;
      // Arms on a tick while hit, drops as soon as hit goes away
      always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= hit[i] & (armed_q | tick);
      end
      always_comb qual[i] = hit[i] & armed_q;
    end
  end

  always_comb irq = |qual;
endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   sts_set,
  input  logic              thresh_tick,
  output logic              irq
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] sts_q;
  logic            en_load;
  logic [NSRC-1:0] sts_clr;

  always_comb begin
    en_load = reg_wr && (reg_sel == SEL_ENABLE);
    sts_clr = (reg_wr && (reg_sel == SEL_STATUS)) ? reg_wdata[NSRC-1:0] : '0;
  end

  irq_gate_enable #(.N(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .load(en_load),
    .load_val(reg_wdata[NSRC-1:0]), .en_q(en_q)
  );

  irq_gate_status #(.N(NSRC)) u_sts (
    .clk(clk), .rst_n(rst_n), .hw_set(sts_set),
    .sw_clr(sts_clr), .sts_q(sts_q)
  );

  irq_gate_defer #(.N(NSRC), .IMM_MASK(IMMEDIATE_MASK)) u_defer (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .sts_q(sts_q),
    .tick(thresh_tick), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[NSRC-1:0] = (reg_sel == SEL_STATUS) ? sts_q : en_q;
  end
endmodule

// File: rtl/irq_gate_checker.sv
module irq_gate_checker
  import irq_gate_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NSRC-1:0]   sts_set,
  input logic              thresh_tick,
  input logic              irq,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   sts_q
);
  // R3 and R5: a set pulse always lands, even against a clear
  assert_set_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set != '0) |=> ((sts_q & $past(sts_set)) == $past(sts_set)));

  // R4: write-one-to-clear with no competing set
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_STATUS && sts_set == '0)
      |=> (sts_q == ($past(sts_q) & ~$past(reg_wdata[NSRC-1:0]))));

  // R6: immediate sources always drive the line
  assert_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & sts_q & IMMEDIATE_MASK) != '0) |-> irq);

  // R7: a rise caused only by deferred sources follows a tick
  assert_defer_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && ((en_q & sts_q & IMMEDIATE_MASK) == '0)) |-> $past(thresh_tick));

  // R9: with nothing qualified the line is low
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & sts_q) == '0) |-> !irq);

  // R2: enable register follows writes
  assert_enable_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_ENABLE) |=> (en_q == $past(reg_wdata[NSRC-1:0])));
endmodule

bind irq_gate_top irq_gate_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .sts_set(sts_set), .thresh_tick(thresh_tick),
  .irq(irq), .en_q(en_q), .sts_q(sts_q)
);

// File: tb/sim_irq_gate_top.sv
module sim_irq_gate_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  sts_set = '0;
  logic        thresh_tick = 1'b0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_gate_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_set(sts_set),
    .thresh_tick(thresh_tick), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic hw_set(input logic [3:0] s);
    sts_set = s;
    @(negedge clk);
    sts_set = '0;
  endtask

  task automatic tick();
    thresh_tick = 1'b1;
    @(negedge clk);
    thresh_tick = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check({31'b0, irq}, 0, "R1 irq");
    rd(1'b0, d); check(d, 0, "R1 enable");
    rd(1'b1, d); check(d, 0, "R1 status");
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr(1'b0, 32'hFFFF_FFF5);
    rd(1'b0, d); check(d, 32'h5, "R2 enable readback");
    wr(1'b0, 32'h0);
    rd(1'b0, d); check(d, 0, "R2 enable cleared");
  endtask

  task automatic t_status_w1c();
    logic [31:0] d;
    hw_set(4'hF);
    rd(1'b1, d); check(d, 32'hF, "R3 status set");
    check({31'b0, irq}, 0, "R3 no irq when disabled");
    wr(1'b1, 32'hFFFF_FFF5);
    rd(1'b1, d); check(d, 32'hA, "R4 clear ones, R2 upper ignored");
    wr(1'b1, 32'h0);
    rd(1'b1, d); check(d, 32'hA, "R4 zero write keeps");
    wr(1'b1, 32'hF);
    rd(1'b1, d); check(d, 0, "R4 all cleared");
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    hw_set(4'h2);
    sts_set = 4'h2; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h2;
    @(negedge clk);
    sts_set = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1'b1, d); check(d, 32'h2, "R5 set beats clear");
    wr(1'b1, 32'hF);
  endtask

  task automatic t_immediate();
    wr(1'b0, 32'hC);
    hw_set(4'h4);
    check({31'b0, irq}, 1, "R6 port change immediate");
    wr(1'b1, 32'h4);
    check({31'b0, irq}, 0, "R9 status clear drops");
    wr(1'b0, 32'h0);
    hw_set(4'h8);
    check({31'b0, irq}, 0, "R6 disabled rollover quiet");
    wr(1'b0, 32'h8);
    check({31'b0, irq}, 1, "R6 enable after status");
    wr(1'b0, 32'h0);
    check({31'b0, irq}, 0, "R9 enable clear drops");
    wr(1'b1, 32'hF);
  endtask

  task automatic t_deferred();
    wr(1'b0, 32'h3);
    hw_set(4'h1);
    check({31'b0, irq}, 0, "R7 completion held");
    idle(3);
    check({31'b0, irq}, 0, "R7 still held without tick");
    tick();
    check({31'b0, irq}, 1, "R7 released after tick");
    tick(); tick();
    check({31'b0, irq}, 1, "R10 level across ticks");
    wr(1'b1, 32'h1);
    check({31'b0, irq}, 0, "R9 acknowledge drops");
    hw_set(4'h2);
    check({31'b0, irq}, 0, "R9 re-set needs new tick");
    tick();
    check({31'b0, irq}, 1, "R7 error released after tick");
    wr(1'b0, 32'h0);
    check({31'b0, irq}, 0, "R9 disable drops deferred");
    wr(1'b0, 32'h3);
    check({31'b0, irq}, 0, "R9 re-enable needs new tick");
    wr(1'b1, 32'hF);
  endtask

  task automatic t_tick_same();
    sts_set = 4'h2; thresh_tick = 1'b1;
    @(negedge clk);
    sts_set = '0; thresh_tick = 1'b0;
    check({31'b0, irq}, 0, "R8 same-cycle tick ignored");
    idle(2);
    check({31'b0, irq}, 0, "R8 still waiting");
    tick();
    check({31'b0, irq}, 1, "R8 later tick releases");
    wr(1'b1, 32'hF);
    wr(1'b0, 32'h0);
  endtask

  task automatic t_level();
    wr(1'b0, 32'hF);
    hw_set(4'h9);
    tick();
    check({31'b0, irq}, 1, "R10 two sources");
    wr(1'b1, 32'h8);
    check({31'b0, irq}, 1, "R10 remains with deferred source");
    wr(1'b1, 32'h1);
    check({31'b0, irq}, 0, "R10 all cleared");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_rw();
    t_status_w1c();
    t_set_wins();
    t_immediate();
    t_deferred();
    t_tick_same();
    t_level();
    finish_run();
  end
endmodule